// File: doc/BRIEF.md
# Stored-Pattern Warning Sign Sequencer

This block drives a flashing roadside warning sign with five lamps. It is a four-state machine. The machine does not derive its next state and lamp pattern from gate equations. Instead it reads them out of a small read-only micromemory. The current state is the micromemory address, and each stored word carries the following state together with the lamp pattern that belongs to it. A small sequencer sits in front of the state register and picks the next address. While the enable switch is on, it takes the address stored in the word, which makes the sign walk through a growing bar of lit lamps. When the switch is off, it forces the idle address, where every lamp is dark.

The lamp lines are loaded into a register on the same edge as the state, so they never change within a cycle. A dwell parameter sets how many clock edges each state is held. The block can therefore run from a fast system clock without an external prescaler. The memory contents are computed at elaboration from the state count and the lamp count, so there is no written-out table.

Top module: `warn_sign_useq`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, that edge loads state 00 and turns every lamp off, whatever the switch does.
- R2: With HOLD_CYCLES = 1 and `sw_on` high, each rising edge advances the 2-bit binary state on `state_o` through 00, 01, 10, 11 and then back to 00.
- R3: A rising edge with `sw_on` low loads state 00 from any state, with all lamps off. The dwell count restarts, so that after the switch returns the first advance takes a full HOLD_CYCLES edges.
- R4: `lamp_o` bit 0 is lamp 1 and bit 4 is lamp 5. The lamp pattern for each state is: 00 gives 5'b00000, 01 gives 5'b00011 (lamps 1 and 2), 10 gives 5'b01111 (lamps 1 to 4) and 11 gives 5'b11111.
- R5: `lamp_o` is registered. It changes only at a rising edge of `clk`, on the same edge as the state, and it is steady for the rest of the cycle.
- R6: With HOLD_CYCLES = N and `sw_on` high, each state is held for exactly N rising edges before it advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sw_on | input | 1 | Enable switch: high runs the sequence, low forces the idle state |
| lamp_o | output | LAMP_N (5) | Registered lamp drive lines, bit 0 is lamp 1 |
| state_o | output | STATE_W (2) | Current state, which is also the micromemory address |

## Verification
Every state has its own lamp pattern. A wrong state register value or a wrong stored word therefore shows on both `state_o` and `lamp_o` in the cycle just after the faulty edge. A dwell counter that is off by one stays hidden until it moves an advance early or late by one edge against the expected schedule of a slow instance. A sequencer that ignores the switch shows at the first edge after the switch drops, because the idle state does not appear there. A lamp register that is not aligned with the state shows as a pattern that disagrees with `state_o` for a whole cycle.

// File: rtl/warn_sign_pkg.sv
package warn_sign_pkg;

   typedef enum logic [1:0] {
      SEL_IDLE = 2'd0,
      SEL_HOLD = 2'd1,
      SEL_STEP = 2'd2
   } seq_sel_e;

   // number of lamps lit in a state: none at idle, all in the last state,
   // otherwise two more per step, capped at the lamp count
   function automatic int unsigned lit_count(input int unsigned addr,
                                             input int unsigned n_states,
                                             input int unsigned n_lamps);
      if (addr == 0) return 0;
      if (addr == n_states - 1) return n_lamps;
      if (2 * addr > n_lamps) return n_lamps;
      return 2 * addr;
   endfunction

endpackage

// File: rtl/warn_sign_rom.sv
module warn_sign_rom #(
   parameter int unsigned STATE_W = 2,
   parameter int unsigned LAMP_N  = 5
) (
   input  logic [STATE_W-1:0] a_addr,
   input  logic [STATE_W-1:0] b_addr,
   output logic [STATE_W-1:0] a_next,
   output logic [LAMP_N-1:0]  a_lamps,
   output logic [LAMP_N-1:0]  b_lamps
);
   import warn_sign_pkg::*;

   localparam int unsigned N_STATES = 1 << STATE_W;
   localparam int unsigned WORD_W   = STATE_W + LAMP_N;

   // word layout: next-state field on top, lamp pattern below, lamp 1 at bit 0
   logic [WORD_W-1:0] words [N_STATES];

   for (genvar a = 0; a < N_STATES; a++) begin : g_word
      localparam int unsigned LIT = lit_count(a, N_STATES, LAMP_N);
      assign words[a][WORD_W-1 -: STATE_W] = STATE_W'((a + 1) % N_STATES);
      for (genvar l = 0; l < LAMP_N; l++) begin : g_lamp
         assign words[a][l] = (l < LIT) ? 1'b1 : 1'b0;
      end
   end

   logic [WORD_W-1:0] a_word;
   assign a_word  = words[a_addr];
   assign a_next  = a_word[WORD_W-1 -: STATE_W];
   assign a_lamps = a_word[LAMP_N-1:0];
   assign b_lamps = words[b_addr][LAMP_N-1:0];

endmodule

// File: rtl/warn_sign_dwell.sv
module warn_sign_dwell #(
   parameter int unsigned HOLD_CYCLES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic done
);
   if (HOLD_CYCLES < 1) begin : g_bad
      $error("warn_sign_dwell: HOLD_CYCLES must be at least 1");
   end

   if (HOLD_CYCLES == 1) begin : g_fast
      assign done = 1'b1;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(HOLD_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (rst || restart) cnt_q <= '0;
         else                cnt_q <= cnt_q + 1'b1;
      end

      assign done = (cnt_q == LAST);

      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
         cnt_q <= LAST);                                           // R6
      AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
         restart |=> cnt_q == '0);                                 // R3
   end

endmodule

// File: rtl/warn_sign_seqsel.sv
module warn_sign_seqsel #(
   parameter int unsigned STATE_W = 2
) (
   input  logic               sw_on,
   input  logic               dwell_done,
   input  logic [STATE_W-1:0] cur_state,
   input  logic [STATE_W-1:0] stored_next,
   output logic [STATE_W-1:0] next_state,
   output logic               restart
);
   import warn_sign_pkg::*;

   seq_sel_e sel;

   always_comb begin
      if (!sw_on)          sel = SEL_IDLE;
      else if (dwell_done) sel = SEL_STEP;
      else                 sel = SEL_HOLD;
   end

   always_comb begin
      unique case (sel)
         SEL_IDLE: next_state = '0;
         SEL_STEP: next_state = stored_next;
         default:  next_state = cur_state;
      endcase
   end

   assign restart = (sel != SEL_HOLD);

endmodule

// File: rtl/warn_sign_useq.sv
module warn_sign_useq #(
   parameter int unsigned STATE_W     = 2,
   parameter int unsigned LAMP_N      = 5,
   parameter int unsigned HOLD_CYCLES = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sw_on,
   output logic [LAMP_N-1:0]  lamp_o,
   output logic [STATE_W-1:0] state_o
);
   if (STATE_W < 1) begin : g_bad_w
      $error("warn_sign_useq: STATE_W must be at least 1");
   end
   if (LAMP_N < 1) begin : g_bad_l
      $error("warn_sign_useq: LAMP_N must be at least 1");
   end

   logic [STATE_W-1:0] state_q;
   logic [LAMP_N-1:0]  lamps_q;
   logic [STATE_W-1:0] stored_next;
   logic [STATE_W-1:0] next_state;
   logic [LAMP_N-1:0]  cur_lamps;
   logic [LAMP_N-1:0]  next_lamps;
   logic               dwell_done;
   logic               restart;

   warn_sign_rom #(.STATE_W(STATE_W), .LAMP_N(LAMP_N)) rom_i (
      .a_addr (state_q),
      .b_addr (next_state),
      .a_next (stored_next),
      .a_lamps(cur_lamps),
      .b_lamps(next_lamps)
   );

   warn_sign_dwell #(.HOLD_CYCLES(HOLD_CYCLES)) dwell_i (
      .clk    (clk),
      .rst    (rst),
      .restart(restart),
      .done   (dwell_done)
   );

   warn_sign_seqsel #(.STATE_W(STATE_W)) sel_i (
      .sw_on      (sw_on),
      .dwell_done (dwell_done),
      .cur_state  (state_q),
      .stored_next(stored_next),
      .next_state (next_state),
      .restart    (restart)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= '0;
         lamps_q <= '0;
      end else begin
         state_q <= next_state;
         lamps_q <= next_lamps;
      end
   end

   assign state_o = state_q;
   assign lamp_o  = lamps_q;

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (state_q == '0 && lamps_q == '0));                   // R1
   AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (sw_on && dwell_done) |=> state_q == STATE_W'($past(state_q) + 1'b1)); // R2
   AST_SW_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
      !sw_on |=> (state_q == '0 && lamps_q == '0));                // R3
   AST_LAMPS_MATCH: assert property (@(posedge clk) disable iff (rst)
      lamps_q == cur_lamps);                                       // R4
   AST_LAMPS_WITH_STATE: assert property (@(posedge clk) disable iff (rst)
      !$stable(lamps_q) |-> !$stable(state_q));                    // R5
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (sw_on && !dwell_done) |=> $stable(state_q));                // R6

endmodule

// File: tb/warn_sign_useq_tb_top.sv
module warn_sign_useq_tb_top;

   localparam int SLOW = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sw  = 1'b0;
   logic [4:0] lamp_f, lamp_s;
   logic [1:0] st_f, st_s;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   warn_sign_useq #(.STATE_W(2), .LAMP_N(5), .HOLD_CYCLES(1)) dut_i (
      .clk(clk), .rst(rst), .sw_on(sw), .lamp_o(lamp_f), .state_o(st_f));

   warn_sign_useq #(.STATE_W(2), .LAMP_N(5), .HOLD_CYCLES(SLOW)) dut_slow_i (
      .clk(clk), .rst(rst), .sw_on(sw), .lamp_o(lamp_s), .state_o(st_s));

   // scoreboard: {fast state, slow state}
   logic [3:0] exp_q [$];
   string      tag_q [$];
   string      stag_q [$];

   logic [1:0] m_sf = 2'd0, m_ss = 2'd0;
   int         m_cs = 0;

   function automatic logic [4:0] pattern(input logic [1:0] s); // R4 table
      case (s)
         2'd0: return 5'b00000;
         2'd1: return 5'b00011;
         2'd2: return 5'b01111;
         default: return 5'b11111;
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // driver: apply one cycle of input and push the expected result
   task automatic step(input logic r, input logic s);
      string tf, ts;
      @(negedge clk);
      rst = r;
      sw  = s;
      @(posedge clk);
      #1;
      if (r) begin
         m_sf = 0; m_ss = 0; m_cs = 0; tf = "R1"; ts = "R1";
      end else if (!s) begin
         m_sf = 0; m_ss = 0; m_cs = 0; tf = "R3"; ts = "R3";
      end else begin
         m_sf = m_sf + 2'd1; tf = "R2"; ts = "R6";
         if (m_cs == SLOW - 1) begin
            m_ss = m_ss + 2'd1; m_cs = 0;
         end else m_cs++;
      end
      exp_q.push_back({m_sf, m_ss});
      tag_q.push_back(tf);
      stag_q.push_back(ts);
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t, ts;
            logic [4:0] lf0, ls0;
            e  = exp_q.pop_front();
            t  = tag_q.pop_front();
            ts = stag_q.pop_front();
            check(t,  "fast state", st_f, e[3:2]);
            check("R4", "fast lamps", lamp_f, pattern(e[3:2]));
            check(ts, "slow state", st_s, e[1:0]);
            check("R4", "slow lamps", lamp_s, pattern(e[1:0]));
            lf0 = lamp_f;
            ls0 = lamp_s;
            #4;
            check("R5", "fast lamps steady in cycle", lamp_f, lf0);
            check("R5", "slow lamps steady in cycle", lamp_s, ls0);
         end
      end
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      // R1: reset with the switch on and off
      step(1, 1); step(1, 0); step(1, 1);
      // R2 / R6: run with the switch on through several wraps
      for (int i = 0; i < 14; i++) step(0, 1);
      // R3: drop the switch mid-sequence, then resume
      step(0, 0); step(0, 0);
      for (int i = 0; i < 5; i++) step(0, 1);
      step(0, 0);
      for (int i = 0; i < 7; i++) step(0, 1);
      // R1: reset in the middle of a run
      step(1, 1);
      for (int i = 0; i < 4; i++) step(0, 1);
      // mixed switch pattern
      lfsr = 8'hA5;
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(0, (lfsr[1:0] != 2'b00));
      end
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule